// File: doc/BRIEF.md
# Guarded Nonvolatile Control Register Sequencer

This block protects a one-byte control register whose watchdog and block-protect fields are treated as nonvolatile. It sits behind a byte-level serial slave front end. From that front end it receives single-cycle events: a bus start, a bus stop, a data byte addressed to the control register, and a register read. It also receives a pulse that reports an attempted write to a write-protected memory block.

Two volatile latches gate any change to the register. The first is a write enable and the second is a register-write enable. The nonvolatile fields change only after an ordered unlock: the byte 0x02, then the byte 0x06, then a committing byte. Each of these steps must be its own transfer, opened by a start and closed by a stop. A byte takes effect only when the stop closes its transfer. A commit starts a busy period of a programmable number of clock cycles, which stands in for the nonvolatile programming time. The block answers every data byte with ACK or NACK, reports a busy flag, and shows the register contents.

Top module: `nvreg_unlock`

## Requirements
- R1: After reset, `reg_out` reads 0x00 and `busy` is low. The layout of `reg_out` is: bit 7 always 0; bits 6:5 the watchdog field; bits 4:3 the upper two protect bits; bit 2 the register-write enable; bit 1 the write enable; bit 0 the lowest protect bit.
- R2: A transfer carrying byte 0x02, with the register-write enable clear, sets the write enable (bit 1) at its stop. No busy period follows.
- R3: A transfer carrying byte 0x06 sets bits 2 and 1 at its stop, provided bit 1 was already set and bit 2 is clear. With bit 1 clear, the byte has no effect.
- R4: While bit 2 is set, a byte with bit 7 = 0, bit 2 = 0 and bit 1 = 1 commits at the stop. Bits 6:3 and bit 0 of the byte are copied into the register, bit 2 clears, bit 1 is kept, and `busy` stays high for exactly BUSY_CYCLES cycles. The sequence 0x02, 0x06, 0x02 zeroes every nonvolatile field.
- R5: While bit 2 is set, a byte with bit 7 = 0, bit 2 = 1 and bit 1 = 1 (for example 0x06) leaves every bit of the register unchanged, and bit 2 stays set.
- R6: A second data byte inside one transfer is answered with NACK, and the stop of that transfer applies nothing, including the first byte.
- R7: Every data byte that arrives while `busy` is high is answered with NACK and has no effect.
- R8: A read pulse returns the current register value on `rd_data`, with `rd_valid` high, one cycle later. Reads never change the latches or fields.
- R9: A `wp_fault` pulse clears bit 2 and leaves all other bits unchanged.
- R10: A byte that matches no accepted pattern for the current state is acknowledged and changes nothing.
- R11: A held byte is applied only by the stop of its own transfer. A repeated start discards it. A byte outside any transfer is answered with NACK and has no effect.
- R12: Every data byte event is answered one cycle later with `ack_valid` high, and `ack` is 1 for ACK and 0 for NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ev_start | input | 1 | Bus start or repeated-start event |
| ev_stop | input | 1 | Bus stop event |
| ev_wbyte | input | 1 | Data byte written to the control register |
| wdata | input | 8 | Value of the data byte |
| ev_read | input | 1 | Control-register read event |
| wp_fault | input | 1 | Attempted write to a protected block |
| ack_valid | output | 1 | Answer to the previous cycle's byte is valid |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| busy | output | 1 | Nonvolatile cycle in progress |
| reg_out | output | 8 | Current register contents |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 8 | Register value captured by the read |

## Verification
The bench builds the block with BUSY_CYCLES set to 20 instead of the default of 1000. At that setting the exact length of the busy window can be counted cycle by cycle. A write placed inside the window can also be shown to get a NACK, and a later write can be shown to succeed once the window closes, all within a short run. Both example sequences, 02h-06h-02h and 02h-06h-06h, are replayed with reads placed between the steps. The bench also covers the two-byte abort, the discarded repeated-start transfer and a protect fault, each against register values predicted in the bench.

// File: rtl/nvreg_unlock.sv
module nvreg_unlock #(
  parameter int BUSY_CYCLES = 1000,
  localparam int BW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_wbyte,
  input  logic [7:0] wdata,
  input  logic       ev_read,
  input  logic       wp_fault,
  output logic       ack_valid,
  output logic       ack,
  output logic       busy,
  output logic [7:0] reg_out,
  output logic       rd_valid,
  output logic [7:0] rd_data
);

  logic          wel, rwel;
  logic [4:0]    nv;
  logic          open_x, have_byte, spoiled;
  logic [7:0]    held;
  logic [BW-1:0] busy_cnt;

  assign busy    = busy_cnt != '0;
  assign reg_out = {1'b0, nv[4:1], rwel, wel, nv[0]};

  wire nv_form    = rwel && !held[7] && held[1];
  wire is_commit  = nv_form && !held[2];
  wire is_wel     = !rwel && held == 8'h02;
  wire is_both    = !rwel && wel && held == 8'h06;
  wire apply      = ev_stop && !ev_start && open_x && have_byte && !spoiled;
  wire byte_ok    = ev_wbyte && open_x && !have_byte && !spoiled && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack       <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      wel       <= 1'b0;
      rwel      <= 1'b0;
      nv        <= '0;
      open_x    <= 1'b0;
      have_byte <= 1'b0;
      spoiled   <= 1'b0;
      held      <= '0;
      busy_cnt  <= '0;
    end else begin
      ack_valid <= ev_wbyte;
      ack       <= byte_ok;
      rd_valid  <= ev_read;
      if (ev_read) rd_data <= reg_out;

      if (busy) busy_cnt <= busy_cnt - 1'b1;

      if (ev_start) begin
        open_x    <= 1'b1;
        have_byte <= 1'b0;
        spoiled   <= 1'b0;
      end else if (ev_stop) begin
        open_x    <= 1'b0;
        have_byte <= 1'b0;
        spoiled   <= 1'b0;
      end else if (ev_wbyte && open_x) begin
        if (byte_ok) begin
          held      <= wdata;
          have_byte <= 1'b1;
        end else begin
          spoiled   <= 1'b1;
        end
      end

      if (apply) begin
        if (is_commit) begin
          nv       <= {held[6:3], held[0]};
          rwel     <= 1'b0;
          busy_cnt <= BW'(BUSY_CYCLES);
        end else if (is_wel) begin
          wel <= 1'b1;
        end else if (is_both) begin
          wel  <= 1'b1;
          rwel <= 1'b1;
        end
      end

      if (wp_fault) rwel <= 1'b0;
    end
  end

endmodule

// File: rtl/nvreg_unlock_chk.sv
module nvreg_unlock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_stop,
  input logic       ev_wbyte,
  input logic       ev_read,
  input logic       wp_fault,
  input logic       ack_valid,
  input logic       ack,
  input logic       busy,
  input logic [7:0] reg_out,
  input logic       rd_valid,
  input logic [7:0] rd_data
);

  AST_BYTE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wbyte |=> ack_valid); // R12

  AST_NO_SPURIOUS_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_wbyte |=> !ack_valid && !ack); // R12

  AST_NACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wbyte && busy |=> !ack); // R7

  AST_WP_CLEARS_RWEL: assert property (@(posedge clk) disable iff (!rst_n)
    wp_fault |=> !reg_out[2]); // R9

  AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_out[2] |-> reg_out[1]); // R3

  AST_NV_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_stop |=> $stable(reg_out[6:3]) && $stable(reg_out[0])); // R11

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read |=> rd_valid && rd_data == $past(reg_out)); // R8

  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !reg_out[7]); // R1

endmodule

bind nvreg_unlock nvreg_unlock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_stop(ev_stop), .ev_wbyte(ev_wbyte),
  .ev_read(ev_read), .wp_fault(wp_fault), .ack_valid(ack_valid), .ack(ack),
  .busy(busy), .reg_out(reg_out), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/nvreg_unlock_bench.sv
`timescale 1ns/1ps
module nvreg_unlock_bench;
  localparam int BUSY = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, ev_wbyte = 0, ev_read = 0, wp_fault = 0;
  logic [7:0] wdata = '0;
  logic ack_valid, ack, busy, rd_valid;
  logic [7:0] reg_out, rd_data;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nvreg_unlock #(.BUSY_CYCLES(BUSY)) u_nvreg_unlock (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_wbyte(ev_wbyte), .wdata(wdata), .ev_read(ev_read), .wp_fault(wp_fault),
    .ack_valid(ack_valid), .ack(ack), .busy(busy), .reg_out(reg_out),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) ev_start = 1; @(negedge clk) ev_start = 0;
  endtask
  task automatic do_stop();
    @(negedge clk) ev_stop = 1; @(negedge clk) ev_stop = 0;
  endtask
  task automatic do_byte(input logic [7:0] b, input bit exp_ack, input string req);
    @(negedge clk) begin ev_wbyte = 1; wdata = b; end
    @(negedge clk) ev_wbyte = 0;
    chk({req, " ack_valid"}, int'(ack_valid), 1);
    chk({req, " ack"}, int'(ack), int'(exp_ack));
  endtask
  task automatic xfer(input logic [7:0] b, input bit exp_ack, input logic [7:0] exp_reg,
                      input string req);
    do_start();
    do_byte(b, exp_ack, req);
    do_stop();
    chk({req, " reg_out"}, int'(reg_out), int'(exp_reg));
  endtask
  task automatic do_read(input logic [7:0] exp, input string req);
    @(negedge clk) ev_read = 1; @(negedge clk) ev_read = 0;
    chk({req, " rd_valid"}, int'(rd_valid), 1);
    chk({req, " rd_data"}, int'(rd_data), int'(exp));
    chk({req, " reg_out after read"}, int'(reg_out), int'(exp));
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reg_out", int'(reg_out), 8'h00);
    chk("R1 busy", int'(busy), 0);
  endtask

  task automatic t_early_bytes();
    xfer(8'h06, 1, 8'h00, "R3 no wel");
    @(negedge clk) begin ev_wbyte = 1; wdata = 8'h02; end
    @(negedge clk) ev_wbyte = 0;
    chk("R11 stray ack", int'(ack), 0);
    chk("R12 stray ack_valid", int'(ack_valid), 1);
    do_stop();
    chk("R11 stray reg", int'(reg_out), 8'h00);
  endtask

  task automatic t_commit_set();
    xfer(8'h02, 1, 8'h02, "R2 set wel");
    chk("R2 no busy", int'(busy), 0);
    do_read(8'h02, "R8 read after wel");
    xfer(8'h55, 1, 8'h02, "R10 unmatched");
    xfer(8'h06, 1, 8'h06, "R3 set rwel");
    do_read(8'h06, "R8 read between");
    xfer(8'h7B, 1, 8'h7B, "R4 commit");
    begin
      int n = 0;
      while (busy) begin @(negedge clk); n++; end
      chk("R4 busy length", n, BUSY);
    end
  endtask

  task automatic t_keep_and_abort();
    xfer(8'h06, 1, 8'h7F, "R3 rwel again");
    xfer(8'h06, 1, 8'h7F, "R5 keep 06");
    do_read(8'h7F, "R8 read rwel held");
    xfer(8'h66, 1, 8'h7F, "R5 keep 66");
    do_start();
    do_byte(8'h02, 1, "R6 first byte");
    do_byte(8'h44, 0, "R6 second byte");
    do_stop();
    chk("R6 abort reg", int'(reg_out), 8'h7F);
    do_start();
    do_byte(8'h02, 1, "R11 pend byte");
    do_start();
    do_stop();
    chk("R11 restart discards", int'(reg_out), 8'h7F);
    xfer(8'h80, 1, 8'h7F, "R10 unmatched rwel");
  endtask

  task automatic t_wp();
    @(negedge clk) wp_fault = 1; @(negedge clk) wp_fault = 0;
    chk("R9 wp clears rwel", int'(reg_out), 8'h7B);
  endtask

  task automatic t_zero_and_busy();
    xfer(8'h02, 1, 8'h7B, "R2 wel kept");
    xfer(8'h06, 1, 8'h7F, "R3 rwel");
    do_read(8'h7F, "R8 read before commit");
    xfer(8'h02, 1, 8'h02, "R4 zero commit");
    chk("R4 busy", int'(busy), 1);
    xfer(8'h06, 0, 8'h02, "R7 nack busy");
    wait_idle();
    xfer(8'h06, 1, 8'h06, "R7 after busy");
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_early_bytes();
    t_commit_set();
    t_keep_and_abort();
    t_wp();
    t_zero_and_busy();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule